// File: doc/BRIEF.md
# Recursive Sequence Deconvolution Engine

The engine recovers an unknown integer sequence f from a recorded sequence y, given the known sequence g with y = f * g, where * is discrete convolution with no carry between columns. Software or a neighbouring block first fills two small sample memories through a shared write port. A select bit picks which sequence is written, and the address and data come with it. It then pulses `start`. The engine works out f one sample at a time, in the manner of polynomial long division. Each output sample takes y(n) and subtracts the products of samples already recovered with the matching g taps, one product per clock. A dedicated divider then divides the result by g(0).

Results are kept in a third memory and are read through a combinational read port while the engine is idle. `done` is a level that stays high from the end of a run until the next accepted start. Two further flags report the run. One shows that it was refused because g(0) is zero. The other shows that at least one division left a remainder.

Top module: `deconv_engine`

## Requirements
- R1: After reset `busy`, `done`, `err_zero` and `inexact` are 0, and every result address reads 0.
- R2: The first result is f(0) = y(0) / g(0).
- R3: For 1 <= n < FLEN (FLEN = YLEN - GLEN + 1), f(n) = (y(n) - sum of f(k)*g(n-k) over 0 <= k < n) / g(0). A tap g(m) with m >= GLEN counts as zero, and writes to g addresses at or above GLEN have no effect.
- R4: If g(0) is 0 when `start` is accepted, no sample is computed and the result memory is unchanged. `err_zero` and `done` rise together one clock later, with `busy` staying 0.
- R5: Each division truncates toward zero. A nonzero remainder carries the sign of the dividend. The stored result is the low DW bits of the quotient in two's complement, and that stored value is what later steps use.
- R6: `inexact` is set when any division of a run leaves a nonzero remainder. It holds until the next accepted `start`, which clears it.
- R7: `busy` is 1 from the clock after an accepted `start` until the run ends. While `busy` is 1, `start` and sample writes (`wr_en`) have no effect.
- R8: `done` rises in the clock after the last result sample is written, or with `err_zero`. It is never high together with `busy`, and it stays high until the next accepted `start`.
- R9: Writes use `wr_sel` = 0 for y and `wr_sel` = 1 for g, with `wr_data` taken as a DW-bit two's-complement sample. `rd_addr` selects result sample f(rd_addr) on `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write one sample into the selected memory |
| wr_sel | input | 1 | 0 selects y, 1 selects g |
| wr_addr | input | AW | Sample index for the write |
| wr_data | input | DW | Signed sample value |
| start | input | 1 | Begin a run (accepted only when idle) |
| rd_addr | input | AW | Result sample index |
| rd_data | output | DW | Signed result sample f(rd_addr), valid while idle |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run finished or was refused |
| err_zero | output | 1 | Last run refused because g(0) = 0 |
| inexact | output | 1 | A division in the last run left a remainder |

## Verification
An exact positive case with a known answer shows the recursion and the subtraction of earlier outputs. Because y is longer than g, it also shows taps being dropped at the top of the window. A case with negative samples and odd quotients separates truncation toward zero from flooring and raises `inexact`. A case whose quotients overflow DW bits shows that later steps reuse the stored, wrapped value. Further runs use a zero g(0), a write beyond the g length, and a write and restart during a run. These show that each of those inputs leaves the results untouched, which a run repeated afterwards confirms.

// File: rtl/deconv_pkg.sv
package deconv_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_MAC  = 2'd2,
    ST_DIV  = 2'd3
  } dc_state_e;
endpackage

// File: rtl/deconv_mem.sv
module deconv_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DW-1:0] cells [DEPTH];

  function automatic logic in_range(input logic [AW-1:0] a);
    return 32'(a) < DEPTH;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) cells[i] <= '0;
    end else if (we && in_range(waddr)) begin
      cells[waddr[IW-1:0]] <= wdata;
    end
  end

  assign rdata = in_range(raddr) ? cells[raddr[IW-1:0]] : '0;
endmodule

// File: rtl/deconv_div.sv
module deconv_div #(
  parameter int ACCW = 19,
  parameter int DW   = 8
) (
  input  logic signed [ACCW-1:0] num,
  input  logic        [DW-1:0]   den_raw,
  output logic        [DW-1:0]   quo,
  output logic signed [ACCW-1:0] rem
);
  function automatic logic signed [ACCW-1:0] widen(input logic [DW-1:0] v);
    return {{(ACCW-DW){v[DW-1]}}, v};
  endfunction

  function automatic logic [DW-1:0] quot_trunc(input logic signed [ACCW-1:0] a,
                                               input logic signed [ACCW-1:0] b);
    if (b == '0) return '0;
    return DW'(a / b);
  endfunction

  function automatic logic signed [ACCW-1:0] rem_trunc(input logic signed [ACCW-1:0] a,
                                                       input logic signed [ACCW-1:0] b);
    if (b == '0) return '0;
    return a % b;
  endfunction

  logic signed [ACCW-1:0] den;
  assign den = widen(den_raw);
  assign quo = quot_trunc(num, den);
  assign rem = rem_trunc(num, den);
endmodule

// File: rtl/deconv_ctrl.sv
module deconv_ctrl
  import deconv_pkg::*;
#(
  parameter int DW   = 8,
  parameter int YLEN = 8,
  parameter int GLEN = 4,
  parameter int AW   = 3,
  parameter int ACCW = 19
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic        [DW-1:0]   y_rd,
  input  logic        [DW-1:0]   g_rd,
  input  logic        [DW-1:0]   f_rd,
  input  logic        [DW-1:0]   div_q,
  input  logic signed [ACCW-1:0] div_r,
  output logic        [AW-1:0]   y_addr,
  output logic        [AW-1:0]   g_addr,
  output logic        [AW-1:0]   f_raddr,
  output logic        [AW-1:0]   f_waddr,
  output logic        [DW-1:0]   f_wdata,
  output logic                   f_we,
  output logic signed [ACCW-1:0] acc_o,
  output logic                   busy,
  output logic                   done,
  output logic                   err_zero,
  output logic                   inexact
);
  localparam int FLEN = YLEN - GLEN + 1;

  dc_state_e              st;
  logic [AW-1:0]          n_q;
  logic [AW-1:0]          k_q;
  logic signed [ACCW-1:0] acc_q;
  logic                   done_q;
  logic                   err_q;
  logic                   inex_q;

  function automatic logic [AW-1:0] first_k(input logic [AW-1:0] n);
    if (32'(n) >= GLEN - 1) return n - AW'(GLEN - 1);
    return '0;
  endfunction

  function automatic logic signed [ACCW-1:0] widen(input logic [DW-1:0] v);
    return {{(ACCW-DW){v[DW-1]}}, v};
  endfunction

  function automatic logic signed [ACCW-1:0] mac_step(input logic signed [ACCW-1:0] a,
                                                      input logic [DW-1:0] fv,
                                                      input logic [DW-1:0] gv);
    logic signed [2*DW-1:0] prod;
    logic signed [ACCW-1:0] prod_w;
    prod   = $signed(fv) * $signed(gv);
    prod_w = {{(ACCW-2*DW){prod[2*DW-1]}}, prod};
    return a + (~prod_w) + ACCW'(1);
  endfunction

  logic last_sample;
  logic mac_end;
  logic g0_zero;

  assign last_sample = (n_q == AW'(FLEN - 1));
  assign mac_end     = (k_q == n_q);
  assign g0_zero     = (g_rd == '0);

  assign y_addr  = n_q;
  assign g_addr  = (st == ST_MAC) ? (n_q - k_q) : '0;
  assign f_raddr = k_q;
  assign f_waddr = n_q;
  assign f_wdata = div_q;
  assign f_we    = (st == ST_DIV);
  assign acc_o   = acc_q;
  assign busy    = (st != ST_IDLE);
  assign done    = done_q;
  assign err_zero = err_q;
  assign inexact = inex_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      n_q    <= '0;
      k_q    <= '0;
      acc_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      inex_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start) begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            inex_q <= 1'b0;
            n_q    <= '0;
            if (g0_zero) begin
              err_q  <= 1'b1;
              done_q <= 1'b1;
            end else begin
              st <= ST_LOAD;
            end
          end
        end
        ST_LOAD: begin
          acc_q <= widen(y_rd);
          k_q   <= first_k(n_q);
          st    <= ST_MAC;
        end
        ST_MAC: begin
          if (mac_end) begin
            st <= ST_DIV;
          end else begin
            acc_q <= mac_step(acc_q, f_rd, g_rd);
            k_q   <= k_q + AW'(1);
          end
        end
        ST_DIV: begin
          if (div_r != '0) inex_q <= 1'b1;
          if (last_sample) begin
            done_q <= 1'b1;
            st     <= ST_IDLE;
          end else begin
            n_q <= n_q + AW'(1);
            st  <= ST_LOAD;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/deconv_engine.sv
module deconv_engine #(
  parameter int DW   = 8,
  parameter int YLEN = 8,
  parameter int GLEN = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     wr_sel,
  input  logic [$clog2(YLEN)-1:0]  wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     start,
  input  logic [$clog2(YLEN)-1:0]  rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic                     busy,
  output logic                     done,
  output logic                     err_zero,
  output logic                     inexact
);
  localparam int AW   = $clog2(YLEN);
  localparam int FLEN = YLEN - GLEN + 1;
  localparam int ACCW = 2 * DW + $clog2(GLEN) + 1;

  logic                   y_we;
  logic                   g_we;
  logic [AW-1:0]          y_addr;
  logic [AW-1:0]          g_addr;
  logic [AW-1:0]          f_raddr_mac;
  logic [AW-1:0]          f_raddr;
  logic [AW-1:0]          f_waddr;
  logic [DW-1:0]          f_wdata;
  logic                   f_we;
  logic [DW-1:0]          y_rd;
  logic [DW-1:0]          g_rd;
  logic [DW-1:0]          f_rd;
  logic signed [ACCW-1:0] acc_w;
  logic [DW-1:0]          quo_w;
  logic signed [ACCW-1:0] rem_w;

  assign y_we    = wr_en && !busy && !wr_sel;
  assign g_we    = wr_en && !busy &&  wr_sel;
  assign f_raddr = busy ? f_raddr_mac : rd_addr;
  assign rd_data = f_rd;

  deconv_mem #(.DW(DW), .DEPTH(YLEN), .AW(AW)) i_ymem (
    .clk(clk), .rst_n(rst_n), .we(y_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(y_addr), .rdata(y_rd)
  );

  deconv_mem #(.DW(DW), .DEPTH(GLEN), .AW(AW)) i_gmem (
    .clk(clk), .rst_n(rst_n), .we(g_we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(g_addr), .rdata(g_rd)
  );

  deconv_mem #(.DW(DW), .DEPTH(FLEN), .AW(AW)) i_fmem (
    .clk(clk), .rst_n(rst_n), .we(f_we), .waddr(f_waddr), .wdata(f_wdata),
    .raddr(f_raddr), .rdata(f_rd)
  );

  deconv_div #(.ACCW(ACCW), .DW(DW)) i_div (
    .num(acc_w), .den_raw(g_rd), .quo(quo_w), .rem(rem_w)
  );

  deconv_ctrl #(.DW(DW), .YLEN(YLEN), .GLEN(GLEN), .AW(AW), .ACCW(ACCW)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .y_rd(y_rd), .g_rd(g_rd), .f_rd(f_rd), .div_q(quo_w), .div_r(rem_w),
    .y_addr(y_addr), .g_addr(g_addr), .f_raddr(f_raddr_mac), .f_waddr(f_waddr),
    .f_wdata(f_wdata), .f_we(f_we), .acc_o(acc_w),
    .busy(busy), .done(done), .err_zero(err_zero), .inexact(inexact)
  );
endmodule

// File: rtl/deconv_chk.sv
module deconv_chk #(
  parameter int DW   = 8,
  parameter int ACCW = 19
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   busy,
  input logic                   done,
  input logic                   err_zero,
  input logic                   inexact,
  input logic                   f_we,
  input logic                   y_we,
  input logic                   g_we,
  input logic signed [ACCW-1:0] div_num,
  input logic        [DW-1:0]   div_den,
  input logic        [DW-1:0]   div_q,
  input logic signed [ACCW-1:0] div_r
);
  function automatic logic signed [ACCW-1:0] sx(input logic [DW-1:0] v);
    return {{(ACCW-DW){v[DW-1]}}, v};
  endfunction

  function automatic logic signed [ACCW-1:0] mag(input logic signed [ACCW-1:0] v);
    return v[ACCW-1] ? -v : v;
  endfunction

  logic [DW-1:0] recon_low;
  assign recon_low = DW'(sx(div_q) * sx(div_den) + div_r);

  // R8
  done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && busy));

  // R8
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && !err_zero) |-> $past(f_we));

  // R7
  no_write_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !(y_we || g_we));

  // R6
  inexact_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inexact && !start) |=> inexact);

  // R4
  zero_refused_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_zero |-> (done && !busy));

  // R2
  div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_we |-> (recon_low == div_num[DW-1:0]));

  // R5
  rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_we |-> (mag(div_r) < mag(sx(div_den))));

  // R5
  rem_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f_we && div_r != '0) |-> (div_r[ACCW-1] == div_num[ACCW-1]));
endmodule

bind deconv_engine deconv_chk #(.DW(DW), .ACCW(ACCW)) i_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .err_zero(err_zero), .inexact(inexact), .f_we(f_we), .y_we(y_we), .g_we(g_we),
  .div_num(acc_w), .div_den(g_rd), .div_q(quo_w), .div_r(rem_w)
);

// File: tb/test_deconv_engine.sv
module test_deconv_engine;
  localparam int DW   = 8;
  localparam int YLEN = 8;
  localparam int GLEN = 4;
  localparam int FLEN = YLEN - GLEN + 1;
  localparam int AW   = $clog2(YLEN);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          wr_sel = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          start = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          busy, done, err_zero, inexact;

  deconv_engine #(.DW(DW), .YLEN(YLEN), .GLEN(GLEN)) i_deconv_engine (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
    .wr_data(wr_data), .start(start), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .done(done), .err_zero(err_zero), .inexact(inexact)
  );

  always #4 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int exp_q[$];
  int exp_f[FLEN];
  int exp_inex;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL R8 watchdog actual=no_done expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic sel, input int a, input int v);
    wr_en = 1'b1; wr_sel = sel; wr_addr = AW'(a); wr_data = DW'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Reference: long-division recursion on wrapped DW-bit samples
  task automatic model(input int yv[YLEN], input int gv[GLEN]);
    int acc;
    logic signed [DW-1:0] t;
    exp_inex = 0;
    for (int n = 0; n < FLEN; n++) begin
      acc = yv[n];
      for (int k = 0; k < n; k++)
        if (n - k < GLEN) acc = acc - exp_f[k] * gv[n - k];
      if (acc % gv[0] != 0) exp_inex = 1;
      t = DW'(acc / gv[0]);
      exp_f[n] = int'(t);
    end
  endtask

  task automatic push_expected();
    for (int i = 0; i < FLEN; i++) exp_q.push_back(exp_f[i]);
  endtask

  task automatic load(input int yv[YLEN], input int gv[GLEN]);
    for (int i = 0; i < YLEN; i++) wr(1'b0, i, yv[i]);
    for (int i = 0; i < GLEN; i++) wr(1'b1, i, gv[i]);
    model(yv, gv);
    push_expected();
  endtask

  task automatic wait_done();
    int t = 0;
    while (!done && t < 1000) begin
      @(negedge clk);
      t++;
    end
  endtask

  task automatic run(input string req);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({req, " busy after start"}, int'(busy), 1);
    check({req, " done low while busy"}, int'(done), 0);
    wait_done();
  endtask

  // Monitor side of the scoreboard: pop and compare results
  task automatic drain(input string req);
    int e;
    logic signed [DW-1:0] got;
    for (int i = 0; i < FLEN; i++) begin
      rd_addr = AW'(i);
      #1;
      got = rd_data;
      e = exp_q.pop_front();
      check(req, int'(got), e);
      @(negedge clk);
    end
  endtask

  initial begin
    logic signed [DW-1:0] s;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 busy", int'(busy), 0);
    check("R1 done", int'(done), 0);
    check("R1 err_zero", int'(err_zero), 0);
    check("R1 inexact", int'(inexact), 0);
    rd_addr = '0; #1;
    check("R1 result zero", int'(rd_data), 0);
    @(negedge clk);

    // R2 R3 R9 known exact case, window drops taps for n = 4
    load('{16, 28, 34, 37, 17, 12, 0, 0}, '{4, 5, 3, 4});
    run("R3");
    check("R8 done after run", int'(done), 1);
    check("R6 exact run", int'(inexact), 0);
    check("R4 no error", int'(err_zero), 0);
    rd_addr = 0; #1; s = rd_data;
    check("R2 f0", int'(s), 4);
    @(negedge clk);
    drain("R3 example");

    // R5 R6 negative samples, truncation toward zero
    load('{-7, 5, 3, -9, 11, 0, 0, 0}, '{2, -3, 1, 0});
    run("R5");
    check("R6 inexact set", int'(inexact), exp_inex);
    rd_addr = 0; #1; s = rd_data;
    check("R5 f0 trunc", int'(s), -3);
    @(negedge clk);
    drain("R5 negative");

    // R5 quotient wraps to DW bits, wrapped value reused
    load('{127, -128, 5, 0, 0, 0, 0, 0}, '{1, 127, 0, 0});
    run("R5");
    check("R6 inexact cleared", int'(inexact), 0);
    drain("R5 wrap");
    push_expected();

    // R4 zero g(0): refused, results unchanged
    wr(1'b1, 0, 0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R4 err_zero", int'(err_zero), 1);
    check("R4 done", int'(done), 1);
    check("R4 busy low", int'(busy), 0);
    drain("R4 results kept");

    // R3 write to g address beyond GLEN is ignored
    load('{9, 4, -6, 7, 3, 8, 0, 0}, '{3, 1, 2, 1});
    wr(1'b1, 5, 9);
    run("R3");
    check("R4 err cleared", int'(err_zero), 0);
    drain("R3 beyond GLEN");

    // R7 write and restart during a run are ignored
    load('{20, -8, 14, 6, -30, 2, 0, 0}, '{5, 2, -1, 3});
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R7 busy", int'(busy), 1);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 1'b0; wr_addr = '0; wr_data = DW'(99); start = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; start = 1'b0;
    check("R7 still busy", int'(busy), 1);
    wait_done();
    drain("R7 during busy");
    push_expected();
    run("R7");
    drain("R7 y unchanged");

    // R8 done holds while idle
    repeat (5) @(negedge clk);
    check("R8 done holds", int'(done), 1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule